// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This block sits between a user process and memory. It turns each logical address into a physical one, so the process only ever hands out logical addresses and only the translated address travels toward memory. A logical address is accepted only when it is strictly smaller than the value in a limit register. An accepted address has the value of a relocation (base) register added to it. A rejected address produces a one-cycle protection-fault pulse, and no physical address is released for it.

Both configuration registers are loaded through a small write port. The write takes effect only while the kernel-mode input is high. If a write is attempted from user mode, both registers stay as they were and a privilege-violation pulse is raised. After reset both registers are zero, so every access faults until the kernel has set up the window. Translation is registered, and its result appears one cycle after the request.

Top module: `reloc_guard`

## Requirements
- R1: Synchronous active-low reset clears base and limit to zero and drives out_valid, out_fault and priv_viol low and out_paddr to zero. A request made right after reset faults.
- R2: A write with cfg_we=1 and kernel_mode=1 loads cfg_wdata into base when cfg_sel=0, or loads its low LADDR_W+1 bits into limit when cfg_sel=1. The new value applies to requests presented from the following cycle onward. A request in the same cycle as the write still sees the old value.
- R3: A write with cfg_we=1 and kernel_mode=0 changes neither base nor limit.
- R4: priv_viol is high for exactly the cycle after each user-mode write attempt, and low otherwise. A kernel-mode write does not raise it.
- R5: A request (req_valid=1) with req_laddr strictly less than limit gives out_valid=1 on the next cycle, with out_paddr = base + req_laddr.
- R6: A request with req_laddr greater than or equal to limit gives out_fault=1 for one cycle on the next cycle, with out_valid=0.
- R7: out_valid and out_fault are never high together, and both are low in the cycle after a cycle with req_valid=0.
- R8: out_paddr is zero whenever out_valid is low, so no physical address is exposed for a fault or an idle cycle.
- R9: limit is LADDR_W+1 bits wide. A limit of 2^LADDR_W makes the whole logical space legal, and a limit of 0 makes every request fault.
- R10: The addition is taken modulo 2^PADDR_W. A sum that overflows wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kernel_mode | input | 1 | High while the processor runs privileged code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_wdata | input | PADDR_W | Configuration write value |
| req_valid | input | 1 | Logical address request strobe |
| req_laddr | input | LADDR_W | Logical address from the user process |
| out_valid | output | 1 | Physical address valid |
| out_paddr | output | PADDR_W | Translated physical address, zero when not valid |
| out_fault | output | 1 | Protection-fault pulse |
| priv_viol | output | 1 | Pulse for a user-mode configuration write |

## Verification
Every result of this block is due on the clock edge after the one that captured its stimulus. That holds for out_valid, out_fault, out_paddr and priv_viol. A configuration write alters translation for requests in the next cycle, not the current one. The bench drives each row of stimulus on a falling edge and lets one rising edge pass. It then samples all four outputs shortly after that edge, so each row's expected values belong to that row alone. Rows that pair a write with a request in the same cycle pin down the old-value rule, and the row after them shows the new value taking hold.

// File: rtl/reloc_pkg.sv
// Package: shared selector encoding for the relocation unit.
// Assumes: configuration selector is one bit wide.
package reloc_pkg;
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/reloc_cfg_regs.sv
// Module: holds the base and limit registers and guards their writes by privilege.
// Assumes: PADDR_W >= LADDR_W + 1, so the write data covers the limit width.
module reloc_cfg_regs
    import reloc_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int PADDR_W = 20,
    localparam int LIM_W  = LADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kernel_mode,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [PADDR_W-1:0] cfg_wdata,
    output logic [PADDR_W-1:0] base_q,
    output logic [LIM_W-1:0]   limit_q,
    output logic               priv_viol
);
    logic kern_wr;
    logic user_wr;

    // Split a write strobe into an accepted write and a rejected attempt.
    always_comb begin
        kern_wr = cfg_we & kernel_mode;
        user_wr = cfg_we & ~kernel_mode;
    end

    // Load the selected register on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (kern_wr) begin
            if (cfg_sel_e'(cfg_sel) == SEL_BASE)
                base_q  <= cfg_wdata;
            else
                limit_q <= cfg_wdata[LIM_W-1:0];
        end
    end

    // Pulse the violation flag one cycle after a user-mode write attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_viol <= 1'b0;
        else        priv_viol <= user_wr;
    end

    // R3: a user-mode write leaves both registers untouched.
    assert_user_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !kernel_mode) |=> ($stable(base_q) && $stable(limit_q)));

    // R4: a kernel write never raises the violation flag.
    assert_kernel_no_viol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && kernel_mode) |=> !priv_viol);

    // R4: the violation flag only follows a user-mode write attempt.
    assert_viol_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !kernel_mode) |=> !priv_viol);
endmodule

// File: rtl/reloc_bound_check.sv
// Module: decides whether a logical address lies strictly below the limit.
// Assumes: limit is one bit wider than the logical address.
module reloc_bound_check #(
    parameter int LADDR_W = 16,
    localparam int LIM_W  = LADDR_W + 1
) (
    input  logic [LADDR_W-1:0] laddr,
    input  logic [LIM_W-1:0]   limit,
    output logic               in_range
);
    // Unsigned compare with the address zero-extended to the limit width.
    always_comb begin
        in_range = ({1'b0, laddr} < limit);
    end
endmodule

// File: rtl/reloc_adder.sv
// Module: adds the relocation base to a logical address, wrapping at the physical width.
// Assumes: PADDR_W >= LADDR_W.
module reloc_adder #(
    parameter int LADDR_W = 16,
    parameter int PADDR_W = 20,
    localparam int PAD_W  = PADDR_W - LADDR_W
) (
    input  logic [PADDR_W-1:0] base,
    input  logic [LADDR_W-1:0] laddr,
    output logic [PADDR_W-1:0] paddr
);
    logic [PADDR_W-1:0] laddr_ext;

    // Zero-extend the logical address when the physical space is wider.
    generate
        if (PAD_W > 0) begin : g_ext
            assign laddr_ext = {{PAD_W{1'b0}}, laddr};
        end else begin : g_same
            assign laddr_ext = laddr;
        end
    endgenerate

    // Modulo-2^PADDR_W sum.
    always_comb begin
        paddr = base + laddr_ext;
    end
endmodule

// File: rtl/reloc_guard.sv
// Module: top of the base-limit relocation unit; one registered cycle from request to result.
// Assumes: requests and configuration writes are synchronous to clk; a write and a
// request in the same cycle see the register values from before that write.
module reloc_guard #(
    parameter int LADDR_W = 16,
    parameter int PADDR_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kernel_mode,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [PADDR_W-1:0] cfg_wdata,
    input  logic               req_valid,
    input  logic [LADDR_W-1:0] req_laddr,
    output logic               out_valid,
    output logic [PADDR_W-1:0] out_paddr,
    output logic               out_fault,
    output logic               priv_viol
);
    localparam int LIM_W = LADDR_W + 1;

    logic [PADDR_W-1:0] base_q;
    logic [LIM_W-1:0]   limit_q;
    logic               in_range;
    logic [PADDR_W-1:0] sum;

    reloc_cfg_regs #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .kernel_mode(kernel_mode),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .base_q     (base_q),
        .limit_q    (limit_q),
        .priv_viol  (priv_viol)
    );

    reloc_bound_check #(.LADDR_W(LADDR_W)) u_bound (
        .laddr   (req_laddr),
        .limit   (limit_q),
        .in_range(in_range)
    );

    reloc_adder #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_add (
        .base (base_q),
        .laddr(req_laddr),
        .paddr(sum)
    );

    // Register the translation result; release an address only for a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_paddr <= '0;
        end else begin
            out_valid <= req_valid & in_range;
            out_fault <= req_valid & ~in_range;
            out_paddr <= (req_valid & in_range) ? sum : '0;
        end
    end

    // R7: valid and fault never coincide.
    assert_valid_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault));

    // R7: no result follows an idle cycle.
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_fault));

    // R6: an address at or above the limit faults on the next cycle.
    assert_fault_on_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_laddr} >= limit_q)) |=> (out_fault && !out_valid));

    // R5: an address below the limit yields a valid result on the next cycle.
    assert_valid_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_laddr} < limit_q)) |=> out_valid);

    // R8: no physical address is exposed unless valid.
    assert_paddr_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_paddr == '0));
endmodule

// File: tb/sim_reloc_guard.sv
// Bench for reloc_guard: a vector table walked once, then directed reset checks.
module sim_reloc_guard;
    localparam int LADDR_W = 16;
    localparam int PADDR_W = 20;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               kernel_mode;
    logic               cfg_we;
    logic               cfg_sel;
    logic [PADDR_W-1:0] cfg_wdata;
    logic               req_valid;
    logic [LADDR_W-1:0] req_laddr;
    logic               out_valid;
    logic [PADDR_W-1:0] out_paddr;
    logic               out_fault;
    logic               priv_viol;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;  // 125 MHz

    reloc_guard #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_laddr(req_laddr), .out_valid(out_valid), .out_paddr(out_paddr),
        .out_fault(out_fault), .priv_viol(priv_viol)
    );

    typedef struct packed {
        logic        kern;
        logic        we;
        logic        sel;
        logic [19:0] wdata;
        logic        rv;
        logic [15:0] laddr;
        logic        e_valid;
        logic        e_fault;
        logic [19:0] e_paddr;
        logic        e_viol;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    // Each row is one cycle of stimulus; expectations are the outputs one edge later.
    localparam vec_t TBL [NV] = '{
        //  kern we sel wdata     rv laddr     val flt paddr     viol req
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'h0000,1'b0,1'b1,20'h0,    1'b0,8'd1 },  // R1 fault after reset
        '{1'b1,1'b1,1'b0,20'h01000,1'b1,16'h0005,1'b0,1'b1,20'h0,    1'b0,8'd2 },  // R2 base written, old limit
        '{1'b1,1'b1,1'b1,20'h00100,1'b1,16'h0005,1'b0,1'b1,20'h0,    1'b0,8'd2 },  // R2 limit write, old value
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'h0005,1'b1,1'b0,20'h01005,1'b0,8'd5 },  // R5
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'h00FF,1'b1,1'b0,20'h010FF,1'b0,8'd5 },  // R5 limit-1
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'h0100,1'b0,1'b1,20'h0,    1'b0,8'd6 },  // R6 equal to limit
        '{1'b0,1'b1,1'b0,20'h55555,1'b1,16'h0010,1'b1,1'b0,20'h01010,1'b1,8'd4 },  // R4 user base write
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'h0010,1'b1,1'b0,20'h01010,1'b0,8'd3 },  // R3 base kept
        '{1'b0,1'b1,1'b1,20'h0FFFF,1'b0,16'h0000,1'b0,1'b0,20'h0,    1'b1,8'd7 },  // R7 idle, R4 viol
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'h0200,1'b0,1'b1,20'h0,    1'b0,8'd3 },  // R3 limit kept
        '{1'b1,1'b1,1'b0,20'hFFFF0,1'b1,16'h0020,1'b1,1'b0,20'h01020,1'b0,8'd2 },  // R2 old base used
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'h0020,1'b1,1'b0,20'h00010,1'b0,8'd10},  // R10 wrap
        '{1'b1,1'b1,1'b1,20'h10000,1'b0,16'h0000,1'b0,1'b0,20'h0,    1'b0,8'd9 },  // R9 full limit
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'hFFFF,1'b1,1'b0,20'h0FFEF,1'b0,8'd9 },  // R9 top address legal
        '{1'b1,1'b1,1'b1,20'h00000,1'b1,16'h0000,1'b1,1'b0,20'hFFFF0,1'b0,8'd2 },  // R2 old limit
        '{1'b0,1'b0,1'b0,20'h0,    1'b1,16'h0000,1'b0,1'b1,20'h0,    1'b0,8'd9 }   // R9 zero limit
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        kernel_mode = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_laddr = '0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_fault", 32'(out_fault), 32'd0);
        check("R1 priv_viol", 32'(priv_viol), 32'd0);
        check("R1 out_paddr", 32'(out_paddr), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            kernel_mode = TBL[i].kern; cfg_we = TBL[i].we; cfg_sel = TBL[i].sel;
            cfg_wdata = TBL[i].wdata; req_valid = TBL[i].rv; req_laddr = TBL[i].laddr;
            @(posedge clk);
            #1;
            check($sformatf("R%0d row%0d valid", TBL[i].req, i), 32'(out_valid), 32'(TBL[i].e_valid));
            check($sformatf("R%0d row%0d fault", TBL[i].req, i), 32'(out_fault), 32'(TBL[i].e_fault));
            check($sformatf("R%0d row%0d paddr", TBL[i].req, i), 32'(out_paddr), 32'(TBL[i].e_paddr));
            check($sformatf("R%0d/R4 row%0d viol", TBL[i].req, i), 32'(priv_viol), 32'(TBL[i].e_viol));
            // R7 and R8 on every row
            check($sformatf("R7 row%0d exclusive", i), 32'(out_valid & out_fault), 32'd0);
            if (!out_valid) check($sformatf("R8 row%0d hidden", i), 32'(out_paddr), 32'd0);
        end

        // Directed: reconfigure, then reset mid-run must clear the window (R1).
        @(negedge clk);
        idle_inputs(); kernel_mode = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 20'h00800;
        @(negedge clk);
        idle_inputs(); req_valid = 1'b1; req_laddr = 16'h0001;
        @(posedge clk); #1;
        check("R5 directed valid", 32'(out_valid), 32'd1);
        check("R5 directed paddr", 32'(out_paddr), 32'hFFFF1);
        @(negedge clk);
        idle_inputs(); rst_n = 1'b0; req_valid = 1'b1; req_laddr = 16'h0001;
        @(posedge clk); #1;
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset fault", 32'(out_fault), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 post-reset fault", 32'(out_fault), 32'd1);
        check("R1 post-reset valid", 32'(out_valid), 32'd0);

        // Directed: two user writes back to back keep priv_viol high two cycles, then low (R4).
        @(negedge clk);
        idle_inputs(); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1;
        #1 check("R4 first pulse", 32'(priv_viol), 32'd1);
        @(negedge clk);
        idle_inputs();
        #1 check("R4 second pulse", 32'(priv_viol), 32'd1);
        @(negedge clk);
        check("R4 pulse ends", 32'(priv_viol), 32'd0);
        req_valid = 1'b1; req_laddr = 16'h0000;
        @(posedge clk); #1;
        check("R3 limit still zero after user writes", 32'(out_fault), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule